// File: doc/BRIEF.md
# Iterative Booth Multiply-Accumulate Unit

This unit multiplies two signed or unsigned words, one bit of the multiplier per clock cycle. A small processor core uses it for its multiply and multiply-accumulate instructions. Each pass uses radix-2 Booth recoding: the current low multiplier bit and the bit shifted out on the step before choose whether the multiplicand is added, subtracted or skipped. Only the low word of the result is kept. Because of that, the multiplicand is shifted left on each step and the running sum stays one word wide. One adder serves every step.

A one-cycle start pulse captures the three operands and the mode. In plain multiply mode the running sum starts at zero. In accumulate mode it starts at the third operand, so adding it costs no extra cycle. The result appears with a one-cycle done pulse a fixed number of cycles after the start. Between runs the result register holds its value. While the unit is busy it ignores any new start.

Top module: `booth_mac_unit`

## Requirements
- R1: In multiply mode (`mac_mode` = 0), `result` equals the low DATA_W bits of `op_a` × `op_b`, for any bit patterns.
- R2: In accumulate mode (`mac_mode` = 1), `result` equals the low DATA_W bits of `op_a` × `op_b` + `op_c`, wrapping modulo 2^DATA_W.
- R3: In multiply mode the value on `op_c` has no effect on `result`.
- R4: `done` first rises DATA_W+2 clock edges after the start, counting the edge that samples `start` as the first (34 edges for DATA_W = 32).
- R5: `done` is high for exactly one cycle per accepted start.
- R6: `busy` rises on the edge that accepts `start`, stays high through the cycle in which `done` is high, and falls on the following edge.
- R7: A `start` pulse seen while `busy` is high is ignored: the run in progress keeps its operands, its result and its timing.
- R8: After reset, `busy`, `done` and `result` are all zero.
- R9: `result` changes only in the cycle in which `done` rises, and holds its value until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| mac_mode | input | 1 | 1 adds `op_c` to the product, 0 plain multiply |
| op_a | input | DATA_W | Multiplicand |
| op_b | input | DATA_W | Multiplier |
| op_c | input | DATA_W | Accumulate operand |
| busy | output | 1 | High while an operation is in flight |
| done | output | 1 | One-cycle pulse, `result` valid |
| result | output | DATA_W | Low word of the product or the product plus accumulate |

## Verification
The bench builds the unit with DATA_W = 32 and MAC_EN = 1. With these values the 34-cycle latency can be checked to the cycle, and the accumulate path is present, so both modes and the effect of `op_c` in each can be checked. The full 32-bit width lets the operand table hit the Booth cases that matter at the top bit: the most negative value squared, all-ones operands, and alternating patterns that switch between add and subtract on every step. It also covers wrap-around of the accumulate sum.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_STEP  = 2'd1,
      SEQ_WRITE = 2'd2,
      SEQ_DONE  = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      BOP_SKIP = 2'd0,
      BOP_ADD  = 2'd1,
      BOP_SUB  = 2'd2
   } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_mac_pkg::*;
(
   input  logic      cur_bit,
   input  logic      prev_bit,
   output booth_op_e op
);
   // 10 -> start of a run of ones: subtract; 01 -> end of run: add
   always_comb begin
      unique case ({cur_bit, prev_bit})
         2'b10:   op = BOP_SUB;
         2'b01:   op = BOP_ADD;
         default: op = BOP_SKIP;
      endcase
   end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
   import booth_mac_pkg::*;
#(
   parameter int STEPS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic write,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE:  if (start) state_d = SEQ_STEP;
         SEQ_STEP:  if (cnt_q == LAST) state_d = SEQ_WRITE;
         SEQ_WRITE: state_d = SEQ_DONE;
         default:   state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == SEQ_STEP) cnt_q <= cnt_q + 1'b1;
         else                     cnt_q <= '0;
      end
   end

   assign load  = (state_q == SEQ_IDLE) && start;
   assign step  = (state_q == SEQ_STEP);
   assign write = (state_q == SEQ_WRITE);
   assign busy  = (state_q != SEQ_IDLE);
   assign done  = (state_q == SEQ_DONE);
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
   import booth_mac_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit MAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              write,
   input  logic              mac_mode,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] op_c,
   output logic [DATA_W-1:0] result
);
   logic [DATA_W-1:0] mcand_q, mplier_q, acc_q, res_q;
   logic              prev_q;
   logic [DATA_W-1:0] init_val, addend, sum;
   logic              carry_in;
   booth_op_e         op;

   generate
      if (MAC_EN) begin : g_mac
         assign init_val = mac_mode ? op_c : '0;
      end else begin : g_mul_only
         logic unused_mac;
         assign unused_mac = ^{mac_mode, op_c};
         assign init_val   = '0;
      end
   endgenerate

   booth_recode u_recode (
      .cur_bit  (mplier_q[0]),
      .prev_bit (prev_q),
      .op       (op)
   );

   // single adder: subtraction via inverted addend plus carry in
   always_comb begin
      carry_in = (op == BOP_SUB);
      addend   = carry_in ? ~mcand_q : mcand_q;
      sum      = (op == BOP_SKIP) ? acc_q : (acc_q + addend + DATA_W'(carry_in));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
         prev_q   <= 1'b0;
      end else if (load) begin
         mcand_q  <= op_a;
         mplier_q <= op_b;
         acc_q    <= init_val;
         prev_q   <= 1'b0;
      end else if (step) begin
         acc_q    <= sum;
         mcand_q  <= mcand_q << 1;
         mplier_q <= mplier_q >> 1;
         prev_q   <= mplier_q[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     res_q <= '0;
      else if (write) res_q <= acc_q;
   end

   assign result = res_q;
endmodule

// File: rtl/booth_mac_unit.sv
module booth_mac_unit
   import booth_mac_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit MAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mac_mode,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] op_c,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result
);
   localparam int LATENCY = DATA_W + 2;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("booth_mac_unit: DATA_W must be at least 4");
      end
      if (LATENCY != DATA_W + 2) begin : g_bad_latency
         $error("booth_mac_unit: latency derivation broken");
      end
   endgenerate

   logic load, step, write;

   booth_seq_ctrl #(.STEPS(DATA_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .write (write),
      .busy  (busy),
      .done  (done)
   );

   booth_datapath #(.DATA_W(DATA_W), .MAC_EN(MAC_EN)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .write    (write),
      .mac_mode (mac_mode),
      .op_a     (op_a),
      .op_b     (op_b),
      .op_c     (op_c),
      .result   (result)
   );
endmodule

// File: rtl/booth_mac_chk.sv
module booth_mac_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] result
);
   localparam int LATENCY = DATA_W + 2;
   localparam int LW      = $clog2(LATENCY + 2) + 1;

   logic [LW-1:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_cnt <= '0;
      else if (start && !busy)   lat_cnt <= '0;
      else if (busy)             lat_cnt <= lat_cnt + 1'b1;
   end

   // R4: done appears exactly LATENCY-1 edges after the accepting edge
   a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (lat_cnt == LW'(LATENCY - 1)));

   // R5
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   a_r6_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r6_busy_covers_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r6_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R7: a run in flight is never cut short
   a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R9
   a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> $rose(done));
endmodule

bind booth_mac_unit booth_mac_chk #(.DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .result (result)
);

// File: tb/sim_booth_mac_unit.sv
module sim_booth_mac_unit;
   localparam int W   = 32;
   localparam int LAT = W + 2;
   localparam int NV  = 10;

   localparam logic [W-1:0] VA [NV] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                                        32'h8000_0000, 32'h0001_0001, 32'h1234_5678, 32'h0000_0007,
                                        32'hFFFF_FFFF, 32'hAAAA_AAAA};
   localparam logic [W-1:0] VB [NV] = '{32'h1234_5678, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                                        32'hFFFF_FFFF, 32'h0001_0001, 32'h9ABC_DEF0, 32'h0000_0006,
                                        32'h0000_0001, 32'h5555_5555};
   localparam logic [W-1:0] VC [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
                                        32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_0005,
                                        32'h0000_0001, 32'h8000_0000};
   localparam logic [NV-1:0] VM = 10'b11_1000_0000; // bit i = mac_mode of vector i

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         mac_mode = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
   logic         busy, done;
   logic [W-1:0] result;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   booth_mac_unit #(.DATA_W(W), .MAC_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mac_mode(mac_mode),
      .op_a(op_a), .op_b(op_b), .op_c(op_c),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // launches one operation; returns edges after the start edge until done
   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] c, input logic m, output int lat);
      @(negedge clk);
      op_a = a; op_b = b; op_c = c; mac_mode = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int lat;
      logic [W-1:0] exp, held;

      // R8: reset state
      repeat (3) @(negedge clk);
      chk("R8 busy", W'(busy), '0);
      chk("R8 done", W'(done), '0);
      chk("R8 result", result, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R1/R2/R3 values, R4 latency
      for (int i = 0; i < NV; i++) begin
         run_op(VA[i], VB[i], VC[i], VM[i], lat);
         exp = VA[i] * VB[i] + (VM[i] ? VC[i] : '0);
         if (VM[i])              chk("R2 mac value", result, exp);
         else if (VC[i] != '0)   chk("R3 op_c ignored", result, exp);
         else                    chk("R1 product", result, exp);
         chk("R4 latency", W'(lat), W'(LAT - 1));
      end

      // R5 and R6: done single cycle, busy through done, low after
      run_op(32'h0000_0003, 32'hFFFF_FFFD, 32'h0, 1'b0, lat);
      chk("R6 busy during done", W'(busy), W'(1));
      chk("R1 small negative", result, 32'hFFFF_FFF7);
      @(negedge clk);
      chk("R5 done drops", W'(done), '0);
      chk("R6 busy drops", W'(busy), '0);

      // R6: busy high right after the accepting edge
      @(negedge clk);
      op_a = 32'd9; op_b = 32'd9; op_c = 32'd0; mac_mode = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R6 busy after start", W'(busy), W'(1));

      // R7: start during the run is ignored
      repeat (8) @(negedge clk);
      op_a = 32'h7777_7777; op_b = 32'h1111_1111; op_c = 32'h1; mac_mode = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 9;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      chk("R7 result kept", result, 32'd81);
      chk("R7 timing kept", W'(lat), W'(LAT - 1));

      // R9: result holds after the run
      held = result;
      @(negedge clk);
      op_a = 32'h5; op_b = 32'h5;
      repeat (6) @(negedge clk);
      chk("R9 result held", result, held);
      chk("R7 no second run", W'(busy), '0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule